// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block serialises bytes onto a single asynchronous line. A host writes a byte into a one-deep holding register; on the next bit tick that finds the transmitter idle, the byte moves into a shift register. The block then emits one frame: a low start bit, 7 or 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. A 3-bit format code selects the frame layout.

The block advances only on a one-cycle bit-rate enable pulse supplied by an external divider. Between frames it marks the line high. When a break is requested while it is idle, it instead holds the line low on every tick. A flag tells the host when the holding register can take another byte.

Top module: `sertx_break`

## Requirements
- R1: A synchronous reset, active high, drives the line to 1, returns the transmitter to idle and sets the empty flag to 1. This applies even when a frame is in progress.
- R2: A write clears the empty flag on the next clock. The flag sets again only on the idle tick that moves the byte into the shift register. A write in that same cycle keeps the flag clear, and the newly written byte is sent next.
- R3: On the tick that loads a byte, the line goes to 0 as the start bit.
- R4: Data bits follow the start bit, least significant bit first, one per tick. The format code sets the count: codes 000 to 011 send 7 bits and codes 100 to 111 send 8 bits.
- R5: A parity bit follows the data. Codes 000, 010 and 110 use even parity, so the bit equals the XOR of the data bits sent. Codes 001, 011 and 111 use odd parity, which is the inverse. Codes 100 and 101 send no parity bit.
- R6: The line is 1 for two stop ticks with codes 000, 001 and 100, and for one stop tick with all other codes. The following tick may start the next frame.
- R7: When idle with no byte waiting, the line is 1 on every tick.
- R8: When break is requested and the transmitter is idle, the line is 0 on every tick and no frame starts. A break requested during a frame does not alter that frame; it takes effect once the frame ends.
- R9: The format is captured when the byte loads. Changing the format code in the middle of a frame does not change that frame.
- R10: The line and the transmit state change only on clocks where the bit-rate enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| wsel | input | 3 | Frame format code |
| brk_req | input | 1 | Break request |
| bit_tick | input | 1 | Bit-rate enable pulse |
| txd | output | 1 | Serial output line |
| tdr_empty | output | 1 | Holding register empty |

## Verification
The bench builds the block with its default DATA_W of 8, so both the 7-bit and the 8-bit frame lengths are exercised. It sends frames under all eight format codes. Bit ticks arrive either every cycle or every third cycle; the sparse case shows that nothing moves between ticks. The every-cycle case lets a write land exactly on a load tick and lets frames run back to back. Break is tested while idle and while a frame is in progress, the format code is changed mid-frame, and reset is applied mid-frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic eight;     // full-width word when set, one bit shorter otherwise
        logic par_en;    // parity bit present
        logic par_odd;   // odd parity when set
        logic two_stop;  // second stop bit
    } word_fmt_t;

    function automatic word_fmt_t decode_wsel(input logic [2:0] w);
        word_fmt_t f;
        f.eight    = w[2];
        f.par_en   = !(w[2] && !w[1]);
        f.par_odd  = w[0];
        f.two_stop = !w[1] && !(w[2] && w[0]);
        return f;
    endfunction

endpackage

// File: rtl/sertx_holding.sv
module sertx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            empty     <= 1'b1;
        end else if (wr_en) begin
            hold_data <= wr_data;
            empty     <= 1'b0;
        end else if (load) begin
            empty     <= 1'b1;
        end
    end

    // R2: a write always leaves the register occupied
    p_write_clears_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !empty);

    // R2: a transfer with no competing write frees the register
    p_load_frees_r2: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> empty);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              brk,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [2:0]        wsel,
    output logic              load,
    output logic              txd
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              extra_stop;
    logic              par_acc;
    word_fmt_t         fmt;
    word_fmt_t         fmt_now;

    assign fmt_now = decode_wsel(wsel);
    assign load    = tick && (state == ST_IDLE) && !brk && hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bits_left  <= '0;
            extra_stop <= 1'b0;
            par_acc    <= 1'b0;
            fmt        <= '0;
            txd        <= 1'b1;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (brk) begin
                        txd <= 1'b0;
                    end else if (hold_full) begin
                        shreg     <= hold_data;
                        fmt       <= fmt_now;
                        bits_left <= fmt_now.eight ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
                        par_acc   <= 1'b0;
                        txd       <= 1'b0;
                        state     <= ST_DATA;
                    end else begin
                        txd <= 1'b1;
                    end
                end
                ST_DATA: begin
                    txd       <= shreg[0];
                    par_acc   <= par_acc ^ shreg[0];
                    shreg     <= shreg >> 1;
                    bits_left <= bits_left - CNT_W'(1);
                    if (bits_left == CNT_W'(1)) begin
                        state      <= fmt.par_en ? ST_PAR : ST_STOP;
                        extra_stop <= fmt.two_stop;
                    end
                end
                ST_PAR: begin
                    txd        <= par_acc ^ fmt.par_odd;
                    extra_stop <= fmt.two_stop;
                    state      <= ST_STOP;
                end
                ST_STOP: begin
                    txd <= 1'b1;
                    if (extra_stop) extra_stop <= 1'b0;
                    else            state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: nothing moves without an enable pulse
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(txd) && $stable(state)));

    // R3: a load produces the start bit and enters the data phase
    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (!txd && state == ST_DATA));

    // R8: break while idle pulls the line low and starts nothing
    p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_IDLE && brk) |=> (!txd && state == ST_IDLE));

    // R6: stop ticks mark the line
    p_stop_high_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_STOP) |=> txd);

    // R7: idle with nothing queued marks the line
    p_idle_mark_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_IDLE && !brk && !hold_full) |=> txd);

endmodule

// File: rtl/sertx_break.sv
module sertx_break #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        wsel,
    input  logic              brk_req,
    input  logic              bit_tick,
    output logic              txd,
    output logic              tdr_empty
);

    logic [DATA_W-1:0] hold_data;
    logic              load;

    sertx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .hold_data (hold_data),
        .empty     (tdr_empty)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .brk       (brk_req),
        .hold_full (!tdr_empty),
        .hold_data (hold_data),
        .wsel      (wsel),
        .load      (load),
        .txd       (txd)
    );

    // R1: reset leaves the line marking and the register empty
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (txd && tdr_empty));

endmodule

// File: tb/sertx_break_test.sv
`timescale 1ns/1ps
module sertx_break_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] wsel = 3'd0;
    logic       brk_req = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       tdr_empty;

    always #2.5 clk = ~clk;

    sertx_break #(.DATA_W(8)) uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wsel      (wsel),
        .brk_req   (brk_req),
        .bit_tick  (bit_tick),
        .txd       (txd),
        .tdr_empty (tdr_empty)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R7";
    int    tick_period = 1;
    int    tick_cnt = 0;
    bit    done = 1'b0;

    // behavioural reference: a queue of line levels still to come
    bit       mq[$];
    bit       m_full = 1'b0;
    bit [7:0] m_hold = 8'h00;
    bit       m_line = 1'b1;

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic build(input bit [7:0] b, input bit [2:0] w);
        int n;
        bit p;
        int stops;
        n = (w >= 3'd4) ? 8 : 7;
        p = 1'b0;
        mq.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            mq.push_back(b[i]);
            p = p ^ b[i];
        end
        if (w != 3'd4 && w != 3'd5) mq.push_back(w[0] ? ~p : p);
        stops = (w == 3'd0 || w == 3'd1 || w == 3'd4) ? 2 : 1;
        for (int i = 0; i < stops; i++) mq.push_back(1'b1);
    endtask

    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_period) begin
            bit_tick <= 1'b1;
            tick_cnt <= 0;
        end else begin
            bit_tick <= 1'b0;
            tick_cnt <= tick_cnt + 1;
        end
    end

    always @(posedge clk) begin : model
        bit loaded;
        loaded = 1'b0;
        if (rst) begin
            mq.delete();
            m_full = 1'b0;
            m_line = 1'b1;
        end else begin
            if (bit_tick) begin
                if (mq.size() > 0)  m_line = mq.pop_front();
                else if (brk_req)   m_line = 1'b0;
                else if (m_full) begin
                    build(m_hold, wsel);
                    m_line = mq.pop_front();
                    loaded = 1'b1;
                end else            m_line = 1'b1;
            end
            if (wr_en) begin
                m_hold = wr_data;
                m_full = 1'b1;
            end else if (loaded) begin
                m_full = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, txd, m_line, "line");
            chk(cur_req, tdr_empty, !m_full, "empty");
        end
    end

    task automatic send(input bit [7:0] b, input bit [2:0] w);
        @(negedge clk);
        wsel = w;
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2", tdr_empty, 1'b0, "empty after write");
    endtask

    task automatic wait_idle();
        while (mq.size() > 0 || m_full) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", txd, 1'b1, "line in reset");
        chk("R1", tdr_empty, 1'b1, "empty in reset");
        rst <= 1'b0;

        cur_req = "R7";
        repeat (6) @(negedge clk);
        chk("R7", txd, 1'b1, "idle mark");

        cur_req = "R4";
        send(8'hA5, 3'd5);
        @(negedge clk);
        chk("R3", txd, 1'b0, "start bit");
        chk("R2", tdr_empty, 1'b1, "empty after load");
        wait_idle();

        cur_req = "R5";
        for (int w = 0; w < 8; w++) begin
            send(8'h3C ^ 8'(w * 37), 3'(w));
            wait_idle();
        end

        cur_req = "R10";
        tick_period = 3;
        for (int w = 0; w < 8; w++) begin
            send(8'hC9 + 8'(w * 11), 3'(w));
            wait_idle();
        end
        tick_period = 1;
        repeat (4) @(negedge clk);

        cur_req = "R6";
        send(8'h01, 3'd0);
        send(8'h80, 3'd2);
        send(8'h7E, 3'd4);
        wait_idle();

        cur_req = "R2";
        @(negedge clk);
        wsel = 3'd5;
        wr_data = 8'h11;
        wr_en = 1'b1;
        @(negedge clk);
        wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2", tdr_empty, 1'b0, "write on load tick keeps full");
        wait_idle();

        cur_req = "R8";
        brk_req = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8", txd, 1'b0, "break while idle");
        send(8'h55, 3'd5);
        repeat (4) @(negedge clk);
        chk("R8", tdr_empty, 1'b0, "byte waits during break");
        brk_req = 1'b0;
        wait_idle();
        send(8'hFF, 3'd5);
        repeat (3) @(negedge clk);
        brk_req = 1'b1;
        while (mq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8", txd, 1'b0, "break after frame");
        brk_req = 1'b0;
        repeat (3) @(negedge clk);

        cur_req = "R9";
        send(8'h5A, 3'd0);
        repeat (3) @(negedge clk);
        wsel = 3'd5;
        wait_idle();

        cur_req = "R1";
        send(8'hC3, 3'd6);
        repeat (4) @(negedge clk);
        rst <= 1'b1;
        @(negedge clk);
        chk("R1", txd, 1'b1, "line after mid-frame reset");
        chk("R1", tdr_empty, 1'b1, "empty after mid-frame reset");
        rst <= 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule